// File: doc/BRIEF.md
# AUX channel Manchester receiver

This block recovers one auxiliary-channel transaction from a single serial line that is sampled at a fixed multiple of the bit rate. It waits on an idle line and locks its bit phase to the first low-to-high edge. It then counts the run of coded zeros that forms the preamble. It recognises the two-high/two-low pattern that closes the preamble. The bits that follow are decoded, with a high-to-low mid-bit edge read as 1 and a low-to-high mid-bit edge read as 0.

The first four decoded bits are reported as the command, together with a classification. The command is either native or I2C-tunnelled, it is either a read, a write or a write-status request, and I2C commands carry a middle-of-transaction flag. The remaining bits are grouped most significant bit first into bytes, and each byte is reported with a one-cycle strobe. A second two-high/two-low pattern ends the transaction. If it arrives on a byte boundary, the block gives a done pulse. Otherwise it flags a truncation.

Line faults are reported as single-cycle error pulses: a bad preamble length, a bit window without a mid-bit edge, a reserved command code, or a truncated payload. After an aborted frame the receiver waits for a quiet line before hunting again. Downstream logic sees only registered pulses and data, and the receiver needs no software setup.

Top module: `aux_manch_rx`

## Requirements
- R1: Inside a bit window, a high first half followed by a low second half decodes as 1, and a low first half followed by a high second half decodes as 0.
- R2: A preamble of PRE_MIN (16) to PRE_MAX (32) coded zeros is accepted. A shorter run ending in the closing pattern, or a run that reaches PRE_MAX+1 zeros, raises `err_preamble` for one cycle and yields no command.
- R3: The closing pattern is two bit windows at a constant high level followed by two at a constant low level. After it ends the preamble, the next four bits are presented once on `cmd` (first received bit in `cmd[3]`) with a one-cycle `cmd_valid`.
- R4: When `cmd[3]`=1 the command is native: `cmd[2:0]`=000 sets `cmd_write`, 001 sets `cmd_read`, and any other value sets `cmd_err`. `cmd_mot` and `cmd_wstat` stay 0 and `cmd_native` is 1.
- R5: When `cmd[3]`=0 the command is I2C: `cmd_mot` equals `cmd[2]`. `cmd[1:0]` of 00 sets `cmd_write`, 01 sets `cmd_read`, 10 sets `cmd_wstat`, and 11 sets `cmd_err`. Exactly one of these four is 1 with each `cmd_valid`.
- R6: Bits after the command are packed with the first bit in `byte_data[7]`, and each complete byte gives a one-cycle `byte_valid`.
- R7: A closing pattern after a whole number of bytes (zero included) gives exactly one `frame_done` pulse.
- R8: A closing pattern after a partial byte, or before the four command bits are complete, gives `err_trunc` and no `frame_done`.
- R9: A bit window with no mid-bit edge, other than the windows of a closing pattern, gives `err_coding` and aborts the frame with no `frame_done`.
- R10: The bit phase is realigned on every mid-bit edge. Data bits of OSR-1 or OSR+1 samples decode correctly.
- R11: While reset is held, every strobe and error output is 0.
- R12: After an aborted frame, the receiver waits for the line to stay low for two bit periods and then decodes the next frame normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, OSR cycles per bit |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Asynchronous serial line, idle low |
| cmd_valid | output | 1 | One-cycle strobe: command fields valid |
| cmd | output | 4 | Decoded command nibble |
| cmd_native | output | 1 | Command is native (cmd[3]=1) |
| cmd_write | output | 1 | Command is a write |
| cmd_read | output | 1 | Command is a read |
| cmd_wstat | output | 1 | Command is an I2C write-status request |
| cmd_mot | output | 1 | I2C middle-of-transaction flag |
| cmd_err | output | 1 | Reserved command code |
| byte_valid | output | 1 | One-cycle strobe: byte_data valid |
| byte_data | output | 8 | Received byte |
| frame_done | output | 1 | Clean end of transaction |
| err_preamble | output | 1 | Preamble length out of range |
| err_coding | output | 1 | Bit window without mid-bit edge |
| err_trunc | output | 1 | Closing pattern on a partial byte or command |

## Verification
The bench builds the receiver with its defaults: 8 samples per bit, a 16 to 32 zero preamble window and a two-flop synchronizer. At this size, frames are short enough to sweep all sixteen command codes and every preamble length from 14 to 34. The same holds for every truncation depth from one to seven bits and payloads of zero to four bytes. Uniform one-sample stretching and shrinking of data bits shows the mid-bit realignment at work. Injected constant-level windows, each followed by a clean frame, cover abort and recovery.

// File: rtl/aux_rx_pkg.sv
package aux_rx_pkg;

  localparam int CMD_BITS = 4;

  // {first half, second half} of one bit window
  typedef enum logic [1:0] {
    SYM_LOW  = 2'b00,
    SYM_ZERO = 2'b01,
    SYM_ONE  = 2'b10,
    SYM_HIGH = 2'b11
  } sym_t;

  typedef struct packed {
    logic native;
    logic wr;
    logic rd;
    logic wstat;
    logic mot;
    logic bad;
  } cmd_class_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SYNC,
    ST_CMD,
    ST_DATA,
    ST_STOP,
    ST_DRAIN
  } fr_state_t;

endpackage

// File: rtl/aux_rx_sync.sv
module aux_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/aux_rx_slicer.sv
module aux_rx_slicer
  import aux_rx_pkg::*;
#(
  parameter int OSR = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic lock_en,
  input  logic unlock,
  output logic sym_valid,
  output sym_t sym
);
  localparam int PW   = $clog2(OSR);
  localparam int HALF = OSR / 2;
  localparam int QA   = OSR / 4;
  localparam int QB   = HALF + OSR / 4;
  localparam int LAST = OSR - 1;

  logic [PW-1:0] ph;
  logic [PW-1:0] eph;
  logic          prev;
  logic          locked;
  logic          a_q;
  logic          b_q;
  logic          edge_w;
  logic          hunt_hit;
  logic          trk_hit;
  logic          realign;

  assign edge_w   = din ^ prev;
  // hunting: only a rising edge can be a preamble mid-bit edge
  assign hunt_hit = lock_en && !locked && edge_w && din;
  assign trk_hit  = locked && edge_w &&
                    (ph >= PW'(HALF - 1)) && (ph <= PW'(HALF + 1));
  assign realign  = hunt_hit || trk_hit;
  assign eph      = realign ? PW'(HALF) : ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= '0;
      prev      <= 1'b0;
      locked    <= 1'b0;
      a_q       <= 1'b0;
      b_q       <= 1'b0;
      sym_valid <= 1'b0;
      sym       <= SYM_LOW;
    end else begin
      prev      <= din;
      sym_valid <= 1'b0;
      if (unlock)        locked <= 1'b0;
      else if (hunt_hit) locked <= 1'b1;
      if ((locked || hunt_hit) && !unlock) begin
        ph <= (eph == PW'(LAST)) ? '0 : eph + 1'b1;
        if (hunt_hit)             a_q <= 1'b0;
        else if (eph == PW'(QA))  a_q <= din;
        if (eph == PW'(QB))       b_q <= din;
        if (locked && eph == PW'(LAST)) begin
          sym_valid <= 1'b1;
          sym       <= sym_t'({a_q, b_q});
        end
      end
    end
  end
endmodule

// File: rtl/aux_rx_cmd_dec.sv
module aux_rx_cmd_dec
  import aux_rx_pkg::*;
(
  input  logic [CMD_BITS-1:0] c,
  output cmd_class_t          cls
);
  always_comb begin
    cls = '0;
    if (c[3]) begin
      cls.native = 1'b1;
      case (c[2:0])
        3'b000:  cls.wr  = 1'b1;
        3'b001:  cls.rd  = 1'b1;
        default: cls.bad = 1'b1;
      endcase
    end else begin
      cls.mot = c[2];
      case (c[1:0])
        2'b00:   cls.wr    = 1'b1;
        2'b01:   cls.rd    = 1'b1;
        2'b10:   cls.wstat = 1'b1;
        default: cls.bad   = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/aux_rx_framer.sv
module aux_rx_framer
  import aux_rx_pkg::*;
#(
  parameter int OSR       = 8,
  parameter int PRE_MIN   = 16,
  parameter int PRE_MAX   = 32,
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 din,
  input  logic                 sym_valid,
  input  sym_t                 sym,
  input  cmd_class_t           cls,
  output logic [CMD_BITS-1:0]  cmd_cand,
  output logic                 lock_en,
  output logic                 unlock,
  output logic                 cmd_valid,
  output logic [CMD_BITS-1:0]  cmd,
  output cmd_class_t           cls_q,
  output logic                 byte_valid,
  output logic [BYTE_BITS-1:0] byte_data,
  output logic                 frame_done,
  output logic                 err_pre,
  output logic                 err_code,
  output logic                 err_trunc
);
  localparam int ZW    = $clog2(PRE_MAX + 1);
  localparam int BCW   = $clog2(BYTE_BITS);
  localparam int QUIET = 2 * OSR;
  localparam int QW    = $clog2(QUIET);

  fr_state_t            st;
  logic [ZW-1:0]        zcnt;
  logic [1:0]           pidx;
  logic [BCW-1:0]       bcnt;
  logic [BYTE_BITS-1:0] sr;
  logic                 partial;
  logic [QW-1:0]        qcnt;
  logic                 bit_w;
  logic                 is_data;
  sym_t                 expect_w;

  assign bit_w    = (sym == SYM_ONE);
  assign is_data  = (sym == SYM_ONE) || (sym == SYM_ZERO);
  assign cmd_cand = {sr[CMD_BITS-2:0], bit_w};
  assign expect_w = (pidx == 2'd1) ? SYM_HIGH : SYM_LOW;
  assign lock_en  = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      zcnt       <= '0;
      pidx       <= '0;
      bcnt       <= '0;
      sr         <= '0;
      partial    <= 1'b0;
      qcnt       <= '0;
      unlock     <= 1'b0;
      cmd_valid  <= 1'b0;
      cmd        <= '0;
      cls_q      <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      frame_done <= 1'b0;
      err_pre    <= 1'b0;
      err_code   <= 1'b0;
      err_trunc  <= 1'b0;
    end else begin
      unlock     <= 1'b0;
      cmd_valid  <= 1'b0;
      byte_valid <= 1'b0;
      frame_done <= 1'b0;
      err_pre    <= 1'b0;
      err_code   <= 1'b0;
      err_trunc  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (sym_valid) begin
            if (sym == SYM_ZERO) begin
              zcnt <= ZW'(1);
              st   <= ST_PRE;
            end else begin
              st     <= ST_DRAIN;
              unlock <= 1'b1;
              qcnt   <= '0;
            end
          end
        end
        ST_PRE: begin
          if (sym_valid) begin
            if (sym == SYM_ZERO) begin
              if (zcnt == ZW'(PRE_MAX)) begin
                err_pre <= 1'b1;
                st      <= ST_DRAIN;
                unlock  <= 1'b1;
                qcnt    <= '0;
              end else begin
                zcnt <= zcnt + 1'b1;
              end
            end else if (sym == SYM_HIGH) begin
              pidx <= 2'd1;
              st   <= ST_SYNC;
            end else begin
              err_code <= 1'b1;
              st       <= ST_DRAIN;
              unlock   <= 1'b1;
              qcnt     <= '0;
            end
          end
        end
        ST_SYNC, ST_STOP: begin
          if (sym_valid) begin
            if (sym != expect_w) begin
              err_code <= 1'b1;
              st       <= ST_DRAIN;
              unlock   <= 1'b1;
              qcnt     <= '0;
            end else if (pidx == 2'd3) begin
              if (st == ST_SYNC) begin
                if (zcnt < ZW'(PRE_MIN)) begin
                  err_pre <= 1'b1;
                  st      <= ST_DRAIN;
                  unlock  <= 1'b1;
                  qcnt    <= '0;
                end else begin
                  bcnt <= '0;
                  st   <= ST_CMD;
                end
              end else begin
                if (partial) err_trunc  <= 1'b1;
                else         frame_done <= 1'b1;
                st     <= ST_IDLE;
                unlock <= 1'b1;
              end
            end else begin
              pidx <= pidx + 1'b1;
            end
          end
        end
        ST_CMD: begin
          if (sym_valid) begin
            if (is_data) begin
              sr <= {sr[BYTE_BITS-2:0], bit_w};
              if (bcnt == BCW'(CMD_BITS - 1)) begin
                cmd_valid <= 1'b1;
                cmd       <= cmd_cand;
                cls_q     <= cls;
                bcnt      <= '0;
                st        <= ST_DATA;
              end else begin
                bcnt <= bcnt + 1'b1;
              end
            end else if (sym == SYM_HIGH) begin
              partial <= 1'b1;
              pidx    <= 2'd1;
              st      <= ST_STOP;
            end else begin
              err_code <= 1'b1;
              st       <= ST_DRAIN;
              unlock   <= 1'b1;
              qcnt     <= '0;
            end
          end
        end
        ST_DATA: begin
          if (sym_valid) begin
            if (is_data) begin
              sr <= {sr[BYTE_BITS-2:0], bit_w};
              if (bcnt == BCW'(BYTE_BITS - 1)) begin
                byte_valid <= 1'b1;
                byte_data  <= {sr[BYTE_BITS-2:0], bit_w};
                bcnt       <= '0;
              end else begin
                bcnt <= bcnt + 1'b1;
              end
            end else if (sym == SYM_HIGH) begin
              partial <= (bcnt != '0);
              pidx    <= 2'd1;
              st      <= ST_STOP;
            end else begin
              err_code <= 1'b1;
              st       <= ST_DRAIN;
              unlock   <= 1'b1;
              qcnt     <= '0;
            end
          end
        end
        ST_DRAIN: begin
          if (din)                         qcnt <= '0;
          else if (qcnt == QW'(QUIET - 1)) st   <= ST_IDLE;
          else                             qcnt <= qcnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aux_manch_rx.sv
module aux_manch_rx
  import aux_rx_pkg::*;
#(
  parameter int OSR         = 8,
  parameter int PRE_MIN     = 16,
  parameter int PRE_MAX     = 32,
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_BITS   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_in,
  output logic                 cmd_valid,
  output logic [3:0]           cmd,
  output logic                 cmd_native,
  output logic                 cmd_write,
  output logic                 cmd_read,
  output logic                 cmd_wstat,
  output logic                 cmd_mot,
  output logic                 cmd_err,
  output logic                 byte_valid,
  output logic [BYTE_BITS-1:0] byte_data,
  output logic                 frame_done,
  output logic                 err_preamble,
  output logic                 err_coding,
  output logic                 err_trunc
);
  logic                rx_s;
  logic                sym_valid;
  sym_t                sym;
  logic                lock_en;
  logic                unlock;
  logic [CMD_BITS-1:0] cmd_cand;
  cmd_class_t          cls;
  cmd_class_t          cls_q;

  aux_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (rx_in),
    .q   (rx_s)
  );

  aux_rx_slicer #(.OSR(OSR)) u_slicer (
    .clk       (clk),
    .rst       (rst),
    .din       (rx_s),
    .lock_en   (lock_en),
    .unlock    (unlock),
    .sym_valid (sym_valid),
    .sym       (sym)
  );

  aux_rx_cmd_dec u_dec (
    .c   (cmd_cand),
    .cls (cls)
  );

  aux_rx_framer #(
    .OSR       (OSR),
    .PRE_MIN   (PRE_MIN),
    .PRE_MAX   (PRE_MAX),
    .BYTE_BITS (BYTE_BITS)
  ) u_framer (
    .clk        (clk),
    .rst        (rst),
    .din        (rx_s),
    .sym_valid  (sym_valid),
    .sym        (sym),
    .cls        (cls),
    .cmd_cand   (cmd_cand),
    .lock_en    (lock_en),
    .unlock     (unlock),
    .cmd_valid  (cmd_valid),
    .cmd        (cmd),
    .cls_q      (cls_q),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .frame_done (frame_done),
    .err_pre    (err_preamble),
    .err_code   (err_coding),
    .err_trunc  (err_trunc)
  );

  assign cmd_native = cls_q.native;
  assign cmd_write  = cls_q.wr;
  assign cmd_read   = cls_q.rd;
  assign cmd_wstat  = cls_q.wstat;
  assign cmd_mot    = cls_q.mot;
  assign cmd_err    = cls_q.bad;
endmodule

// File: rtl/aux_manch_rx_chk.sv
module aux_manch_rx_chk (
  input logic clk,
  input logic rst,
  input logic cmd_valid,
  input logic cmd_native,
  input logic cmd_write,
  input logic cmd_read,
  input logic cmd_wstat,
  input logic cmd_mot,
  input logic cmd_err,
  input logic byte_valid,
  input logic frame_done,
  input logic err_preamble,
  input logic err_coding,
  input logic err_trunc
);
  logic in_frame;
  logic any_end;

  assign any_end = frame_done | err_preamble | err_coding | err_trunc;

  always_ff @(posedge clk) begin
    if (rst)            in_frame <= 1'b0;
    else if (cmd_valid) in_frame <= 1'b1;
    else if (any_end)   in_frame <= 1'b0;
  end

  // R11: outputs quiet the cycle after reset is seen
  p_quiet_reset_r11: assert property (@(posedge clk)
    rst |=> !cmd_valid && !byte_valid && !frame_done &&
            !err_preamble && !err_coding && !err_trunc);

  // R4: native commands carry no I2C-only flags
  p_native_flags_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_native |-> !cmd_mot && !cmd_wstat);

  // R5: exactly one operation class per command
  p_one_class_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $countones({cmd_write, cmd_read, cmd_wstat, cmd_err}) == 1);

  // R6: bytes appear only after a command of the same frame
  p_byte_in_frame_r6: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> in_frame);

  // R6: the byte strobe lasts one cycle
  p_byte_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);

  // R7: a frame ends in at most one way
  p_single_end_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({frame_done, err_trunc, err_coding, err_preamble}));

  // R8: done only follows a frame that produced a command
  p_done_after_cmd_r8: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> in_frame);
endmodule

bind aux_manch_rx aux_manch_rx_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmd_valid    (cmd_valid),
  .cmd_native   (cmd_native),
  .cmd_write    (cmd_write),
  .cmd_read     (cmd_read),
  .cmd_wstat    (cmd_wstat),
  .cmd_mot      (cmd_mot),
  .cmd_err      (cmd_err),
  .byte_valid   (byte_valid),
  .frame_done   (frame_done),
  .err_preamble (err_preamble),
  .err_coding   (err_coding),
  .err_trunc    (err_trunc)
);

// File: tb/tb_aux_manch_rx.sv
module tb_aux_manch_rx;
  localparam int OSR  = 8;
  localparam int HALF = OSR / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx  = 1'b0;
  always #4 clk = ~clk;

  logic       cmd_valid, cmd_native, cmd_write, cmd_read, cmd_wstat, cmd_mot, cmd_err;
  logic [3:0] cmd;
  logic       byte_valid, frame_done, err_preamble, err_coding, err_trunc;
  logic [7:0] byte_data;

  aux_manch_rx dut (
    .clk(clk), .rst(rst), .rx_in(rx),
    .cmd_valid(cmd_valid), .cmd(cmd), .cmd_native(cmd_native),
    .cmd_write(cmd_write), .cmd_read(cmd_read), .cmd_wstat(cmd_wstat),
    .cmd_mot(cmd_mot), .cmd_err(cmd_err), .byte_valid(byte_valid),
    .byte_data(byte_data), .frame_done(frame_done),
    .err_preamble(err_preamble), .err_coding(err_coding), .err_trunc(err_trunc)
  );

  int total = 0;
  int bad   = 0;

  // event monitor
  int         m_cmd = 0, m_byte = 0, m_done = 0, m_epre = 0, m_ecode = 0, m_etr = 0;
  logic [3:0] m_cmdv;
  logic [5:0] m_cls;
  logic [7:0] blog [0:255];

  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_valid) begin
        m_cmd++;
        m_cmdv = cmd;
        m_cls  = {cmd_native, cmd_write, cmd_read, cmd_wstat, cmd_mot, cmd_err};
      end
      if (byte_valid) begin
        blog[m_byte % 256] = byte_data;
        m_byte++;
      end
      if (frame_done)   m_done++;
      if (err_preamble) m_epre++;
      if (err_coding)   m_ecode++;
      if (err_trunc)    m_etr++;
    end
  end

  int b_cmd, b_byte, b_done, b_epre, b_ecode, b_etr;

  task automatic snap();
    b_cmd = m_cmd; b_byte = m_byte; b_done = m_done;
    b_epre = m_epre; b_ecode = m_ecode; b_etr = m_etr;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(input logic lv, input int n);
    rx = lv;
    repeat (n) @(negedge clk);
  endtask

  // preamble, closing pattern, bits (MSB of the used field first), closing pattern
  task automatic send_frame(input int npre, input logic [63:0] bits, input int nbits,
                            input int jit, input int viol_at, input logic vlvl);
    for (int i = 0; i < npre; i++) begin
      put(1'b0, HALF);
      put(1'b1, HALF);
    end
    put(1'b1, 2 * OSR);
    put(1'b0, 2 * OSR);
    for (int i = 0; i < nbits; i++) begin
      logic b;
      b = bits[nbits - 1 - i];
      if (i == viol_at) put(vlvl, OSR);
      else begin
        put(b, HALF + ((jit > 0) ? 1 : 0));
        put(!b, HALF - ((jit < 0) ? 1 : 0));
      end
    end
    put(1'b1, 2 * OSR);
    put(1'b0, 2 * OSR);
    put(1'b0, 48);
  endtask

  function automatic logic [5:0] exp_cls(input logic [3:0] c);
    logic n, w, r, ws, m, e;
    n = c[3]; w = 0; r = 0; ws = 0; m = 0; e = 0;
    if (n) begin
      w = (c[2:0] == 3'd0);
      r = (c[2:0] == 3'd1);
      e = !(w || r);
    end else begin
      m  = c[2];
      w  = (c[1:0] == 2'd0);
      r  = (c[1:0] == 2'd1);
      ws = (c[1:0] == 2'd2);
      e  = (c[1:0] == 2'd3);
    end
    return {n, w, r, ws, m, e};
  endfunction

  function automatic logic [7:0] pat_byte(input int k);
    return 8'((k * 37 + 8'h5A) & 8'hFF);
  endfunction

  // clean frame with n bytes, checking bytes and done
  task automatic run_bytes(input int n, input int jit, input string tag);
    logic [63:0] v;
    v = 64'h9;
    for (int k = 0; k < n; k++) v = (v << 8) | 64'(pat_byte(k));
    snap();
    send_frame(20, v, 4 + 8 * n, jit, -1, 1'b0);
    chk(m_byte - b_byte == n, {tag, " byte count"}, m_byte - b_byte, n);
    for (int k = 0; k < n; k++)
      chk(blog[(b_byte + k) % 256] == pat_byte(k), {tag, " byte value"},
          int'(blog[(b_byte + k) % 256]), int'(pat_byte(k)));
    chk(m_done - b_done == 1, {tag, " done"}, m_done - b_done, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    // R11: reset state
    chk({cmd_valid, byte_valid, frame_done, err_preamble, err_coding, err_trunc} == 6'b0,
        "R11 outputs in reset",
        int'({cmd_valid, byte_valid, frame_done, err_preamble, err_coding, err_trunc}), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R3 R4 R5: all command codes, one byte each
    for (int c = 0; c < 16; c++) begin
      snap();
      send_frame(16, {52'd0, 4'(c), 8'h3C}, 12, 0, -1, 1'b0);
      chk(m_cmd - b_cmd == 1, "R3 one command per frame", m_cmd - b_cmd, 1);
      chk(m_cmdv == 4'(c), "R3 command value", int'(m_cmdv), c);
      chk(m_cls == exp_cls(4'(c)), c[3] ? "R4 native class" : "R5 i2c class",
          int'(m_cls), int'(exp_cls(4'(c))));
      chk(blog[b_byte % 256] == 8'h3C, "R1 byte polarity", int'(blog[b_byte % 256]), 8'h3C);
      chk(m_done - b_done == 1, "R7 done", m_done - b_done, 1);
    end

    // R2: preamble length sweep
    for (int n = 14; n <= 34; n++) begin
      bit ok;
      ok = (n >= 16) && (n <= 32);
      snap();
      send_frame(n, 64'h9A5, 12, 0, -1, 1'b0);
      chk((m_cmd - b_cmd) == (ok ? 1 : 0), "R2 command after preamble", m_cmd - b_cmd, ok ? 1 : 0);
      chk(ok ? (m_epre == b_epre) : (m_epre > b_epre), "R2 preamble error",
          m_epre - b_epre, ok ? 0 : 1);
      chk((m_done - b_done) == (ok ? 1 : 0), "R2 done", m_done - b_done, ok ? 1 : 0);
    end

    // R6 R7: payload sizes
    for (int n = 0; n <= 4; n++) run_bytes(n, 0, "R6 R7 payload");

    // R8: truncated payload, 1..7 extra bits
    for (int k = 1; k <= 7; k++) begin
      logic [63:0] v;
      v = (64'h8C3 << k) | 64'((1 << k) - 1) & 64'h55;
      snap();
      send_frame(18, v, 12 + k, 0, -1, 1'b0);
      chk(m_etr - b_etr == 1, "R8 truncation", m_etr - b_etr, 1);
      chk(m_done == b_done, "R8 no done", m_done - b_done, 0);
    end
    // R8: stop inside the command
    snap();
    send_frame(18, 64'h2, 2, 0, -1, 1'b0);
    chk(m_etr - b_etr == 1, "R8 short command", m_etr - b_etr, 1);
    chk(m_cmd == b_cmd, "R8 no command", m_cmd - b_cmd, 0);

    // R9: constant-low window in data, then R12 recovery
    snap();
    send_frame(20, 64'h9A5C3, 20, 0, 9, 1'b0);
    chk(m_ecode > b_ecode, "R9 low window", m_ecode - b_ecode, 1);
    chk(m_done == b_done, "R9 no done", m_done - b_done, 0);
    run_bytes(2, 0, "R12 after low violation");

    // R9: constant-high window followed by data
    snap();
    send_frame(20, 64'h9A5C3, 20, 0, 6, 1'b1);
    chk(m_ecode > b_ecode, "R9 high window", m_ecode - b_ecode, 1);
    chk(m_done == b_done, "R9 no done high", m_done - b_done, 0);
    run_bytes(1, 0, "R12 after high violation");

    // R10: stretched and shrunk data bits
    run_bytes(3, 1, "R10 slow bits");
    run_bytes(3, -1, "R10 fast bits");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule